// File: doc/BRIEF.md
# Eight-Step Accumulator Processor

This block is a small 8-bit processor built around a single accumulator. The program counter, the instruction register, the memory address and data registers and a 256-byte RAM sit inside it. Every instruction, whatever it does, takes the same eight clock steps. A timing sequencer counts these steps and raises one one-hot strobe per step. A control decoder combines the strobe with the decoded opcode to drive the datapath.

Programs and data go into the RAM through a preload port while reset is held. Once reset is released, the core fetches from address 0 and runs until it meets a halt instruction. It then freezes and raises `halted`. The accumulator and the program counter are visible at all times on debug outputs.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter, the accumulator and the step count become 0 and `halted` becomes 0.
- R2: A clock edge with `pre_we` high writes `pre_data` into RAM at `pre_addr`. This applies even during reset, and the preload takes priority over a write from the core.
- R3: Every instruction lasts exactly eight clock cycles. Counting the first rising edge after reset release as edge 1, a halt instruction that is the k-th instruction executed (k counted from 0) raises `halted` at edge 8k+4.
- R4: The first three steps of every instruction do three things: they read the byte at the program counter, load the opcode into the instruction register, and add 1 to the program counter. The instruction register changes only in step 2.
- R5: The opcode is bits 7:4 of the instruction byte, and bits 3:0 are ignored. The encodings are 0x0 no-op, 0x1 store, 0x2 load, 0x3 add, 0x4 or, 0x5 and, 0x6 invert, 0x8 jump, 0x9 jump-if-negative, 0xA jump-if-zero and 0xF halt. The decoder asserts exactly one of its 11 lines. Codes 0x7 and 0xB to 0xE decode as the single-byte no-op.
- R6: Load, add, or and and are two-byte instructions: the opcode byte is followed by an operand address. Each writes into the accumulator the operand byte itself, the sum modulo 256, the bitwise OR or the bitwise AND, respectively.
- R7: The invert instruction is one byte long and replaces the accumulator with its bitwise complement.
- R8: The store instruction (two bytes) writes the accumulator into RAM at the operand address and leaves the accumulator unchanged.
- R9: The negative flag equals accumulator bit 7, and the zero flag is 1 exactly when the accumulator is 0.
- R10: The jump instruction (two bytes) loads the operand byte into the program counter.
- R11: Jump-if-negative and jump-if-zero behave exactly as the jump when their flag is 1. When the flag is 0 they do nothing except skip the operand byte, so the program counter advances by 2 over the instruction.
- R12: After a halt, the program counter stays at the halt address plus 1. The program counter, the accumulator and `halted` all stay frozen until reset.
- R13: The program counter changes only by increments (steps 1 and 4) or by a taken jump (step 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_we | input | 1 | RAM preload write strobe |
| pre_addr | input | 8 | RAM preload address |
| pre_data | input | 8 | RAM preload data |
| halted | output | 1 | Core has executed a halt |
| acc_dbg | output | 8 | Accumulator value |
| pc_dbg | output | 8 | Program counter value |

## Verification
The bound checker watches several properties on every cycle:
- the step counter advances by one, wrapping modulo 8, while running;
- the instruction register, the program counter and the accumulator move only in their permitted steps;
- the flags track the accumulator;
- the decoder output is one-hot;
- a halt freezes the core.

The arithmetic results need the bench's scenarios, as do the store-then-reload round trip, the ignored low opcode nibble, the taken or skipped conditional jumps, and the exact halt cycle. The bench sweeps operand pairs for each ALU operation, all 256 accumulator values through both conditional jumps, and every unused opcode.

// File: rtl/cpu_pkg.sv
// Shared definitions for the accumulator processor: widths, opcode
// field values, decoder line indices, ALU selections and the control word.
// Assumes an 8-step instruction frame and a 4-bit opcode field.
package cpu_pkg;
    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int OPW     = 4;
    localparam int STEPS   = 8;
    localparam int SW      = $clog2(STEPS);
    localparam int NLINES  = 11;

    localparam logic [OPW-1:0] OP_NOP = 4'h0;
    localparam logic [OPW-1:0] OP_STA = 4'h1;
    localparam logic [OPW-1:0] OP_LDA = 4'h2;
    localparam logic [OPW-1:0] OP_ADD = 4'h3;
    localparam logic [OPW-1:0] OP_OR  = 4'h4;
    localparam logic [OPW-1:0] OP_AND = 4'h5;
    localparam logic [OPW-1:0] OP_NOT = 4'h6;
    localparam logic [OPW-1:0] OP_JMP = 4'h8;
    localparam logic [OPW-1:0] OP_JN  = 4'h9;
    localparam logic [OPW-1:0] OP_JZ  = 4'hA;
    localparam logic [OPW-1:0] OP_HLT = 4'hF;

    localparam int LN_NOP = 0;
    localparam int LN_STA = 1;
    localparam int LN_LDA = 2;
    localparam int LN_ADD = 3;
    localparam int LN_OR  = 4;
    localparam int LN_AND = 5;
    localparam int LN_NOT = 6;
    localparam int LN_JMP = 7;
    localparam int LN_JN  = 8;
    localparam int LN_JZ  = 9;
    localparam int LN_HLT = 10;

    typedef enum logic [2:0] {
        ALU_PASS = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_OR   = 3'd2,
        ALU_AND  = 3'd3,
        ALU_INV  = 3'd4
    } alu_sel_t;

    typedef struct packed {
        logic     mar_ld;
        logic     mar_from_bus;
        logic     mem_rd;
        logic     mem_wr;
        logic     pc_inc;
        logic     pc_ld;
        logic     ir_ld;
        logic     acc_ld;
        alu_sel_t alu_sel;
        logic     halt;
    } ctrl_t;
endpackage

// File: rtl/cpu_sequencer.sv
// Timing sequencer: counts instruction steps 0..STEPS-1 and wraps, and
// publishes the count both binary and as one-hot step strobes.
// Assumes run is dropped to freeze the core; reset returns to step 0.
module cpu_sequencer #(
    parameter int STEPS = 8,
    localparam int SW = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [SW-1:0]    step,
    output logic [STEPS-1:0] step_oh
);
    logic [SW-1:0] cnt_q;

    // Advance the step count while running, wrapping after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == SW'(STEPS - 1)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + SW'(1);
            end
        end
    end

    // One strobe per step.
    for (genvar g = 0; g < STEPS; g++) begin : g_strobe
        assign step_oh[g] = (cnt_q == SW'(g));
    end

    assign step = cnt_q;
endmodule

// File: rtl/cpu_ctrl_decode.sv
// Opcode decoder and control word generator. Decodes the 4-bit opcode into
// 11 one-hot lines, folds the conditional jumps onto either the jump or
// an operand-skipping no-op, and emits the control word for the current step.
// Assumes steps 0..2 are the common fetch and the opcode is valid from step 3.
module cpu_ctrl_decode
    import cpu_pkg::*;
(
    input  logic [OPW-1:0]    opcode,
    input  logic [STEPS-1:0]  step_oh,
    input  logic              flag_n,
    input  logic              flag_z,
    output logic [NLINES-1:0] lines,
    output ctrl_t             ctrl
);
    logic mem_op;
    logic load_op;
    logic jump_go;
    logic jump_skip;
    alu_sel_t exec_sel;

    // Opcode to one-hot instruction line; unused codes fall to no-op.
    always_comb begin
        lines = '0;
        unique case (opcode)
            OP_STA:  lines[LN_STA] = 1'b1;
            OP_LDA:  lines[LN_LDA] = 1'b1;
            OP_ADD:  lines[LN_ADD] = 1'b1;
            OP_OR:   lines[LN_OR]  = 1'b1;
            OP_AND:  lines[LN_AND] = 1'b1;
            OP_NOT:  lines[LN_NOT] = 1'b1;
            OP_JMP:  lines[LN_JMP] = 1'b1;
            OP_JN:   lines[LN_JN]  = 1'b1;
            OP_JZ:   lines[LN_JZ]  = 1'b1;
            OP_HLT:  lines[LN_HLT] = 1'b1;
            default: lines[LN_NOP] = 1'b1;
        endcase
    end

    // Instruction classes and the conditional-jump selector.
    always_comb begin
        load_op   = lines[LN_LDA] | lines[LN_ADD] | lines[LN_OR] | lines[LN_AND];
        mem_op    = load_op | lines[LN_STA];
        jump_go   = lines[LN_JMP] | (lines[LN_JN] & flag_n) | (lines[LN_JZ] & flag_z);
        jump_skip = (lines[LN_JN] & ~flag_n) | (lines[LN_JZ] & ~flag_z);
        if (lines[LN_ADD]) begin
            exec_sel = ALU_ADD;
        end else if (lines[LN_OR]) begin
            exec_sel = ALU_OR;
        end else if (lines[LN_AND]) begin
            exec_sel = ALU_AND;
        end else begin
            exec_sel = ALU_PASS;
        end
    end

    // Per-step control word.
    always_comb begin
        ctrl = '0;
        ctrl.alu_sel = ALU_PASS;
        if (step_oh[0]) begin
            ctrl.mar_ld = 1'b1;
        end
        if (step_oh[1]) begin
            ctrl.mem_rd = 1'b1;
            ctrl.pc_inc = 1'b1;
        end
        if (step_oh[2]) begin
            ctrl.ir_ld = 1'b1;
        end
        if (step_oh[3]) begin
            ctrl.mar_ld = mem_op | jump_go | jump_skip;
            if (lines[LN_NOT]) begin
                ctrl.acc_ld  = 1'b1;
                ctrl.alu_sel = ALU_INV;
            end
            ctrl.halt = lines[LN_HLT];
        end
        if (step_oh[4]) begin
            ctrl.mem_rd = mem_op | jump_go | jump_skip;
            ctrl.pc_inc = mem_op | jump_skip;
        end
        if (step_oh[5]) begin
            ctrl.mar_ld       = mem_op;
            ctrl.mar_from_bus = mem_op;
            ctrl.pc_ld        = jump_go;
        end
        if (step_oh[6]) begin
            ctrl.mem_rd = load_op;
            ctrl.mem_wr = lines[LN_STA];
        end
        if (step_oh[7]) begin
            ctrl.acc_ld  = load_op;
            ctrl.alu_sel = exec_sel;
        end
    end
endmodule

// File: rtl/cpu_alu_acc.sv
// ALU, accumulator and flags. The ALU result is registered into the
// accumulator on acc_ld, and the flags are registered from the same result.
// Assumes the operand comes from the memory data register.
module cpu_alu_acc
    import cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_ld,
    input  alu_sel_t      alu_sel,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] acc,
    output logic          flag_n,
    output logic          flag_z
);
    logic [DW-1:0] result;

    // Combinational ALU.
    always_comb begin
        unique case (alu_sel)
            ALU_ADD: result = acc + operand;
            ALU_OR:  result = acc | operand;
            ALU_AND: result = acc & operand;
            ALU_INV: result = ~acc;
            default: result = operand;
        endcase
    end

    // Accumulator and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b1;
        end else if (acc_ld) begin
            acc    <= result;
            flag_n <= result[DW-1];
            flag_z <= (result == '0);
        end
    end
endmodule

// File: rtl/cpu_memory.sv
// Memory unit: address source mux, address register, RAM and data
// register. Reads land in the data register; writes store wdata at the
// held address. The preload port writes the RAM directly and wins over the core.
// Assumes the RAM contents are not cleared by reset.
module cpu_memory #(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mar_ld,
    input  logic          mar_from_bus,
    input  logic [AW-1:0] pc,
    input  logic          mem_rd,
    input  logic          mem_wr,
    input  logic [DW-1:0] wdata,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    output logic [DW-1:0] mdr
);
    logic [DW-1:0] ram [DEPTH];
    logic [AW-1:0] mar_q;
    logic [AW-1:0] mar_src;

    // Address source: program counter or data bus.
    always_comb begin
        mar_src = mar_from_bus ? mdr[AW-1:0] : pc;
    end

    // Address and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            mdr   <= '0;
        end else begin
            if (mar_ld) begin
                mar_q <= mar_src;
            end
            if (mem_rd) begin
                mdr <= ram[mar_q];
            end
        end
    end

    // RAM write port, preload first.
    always_ff @(posedge clk) begin
        if (pre_we) begin
            ram[pre_addr] <= pre_data;
        end else if (mem_wr && rst_n) begin
            ram[mar_q] <= wdata;
        end
    end
endmodule

// File: rtl/acc_cpu.sv
// Top of the accumulator processor: program counter, opcode register and
// halt latch, wiring the sequencer, control decoder, ALU and memory unit.
// Assumes programs are preloaded while rst_n is low.
module acc_cpu
    import cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    output logic          halted,
    output logic [DW-1:0] acc_dbg,
    output logic [AW-1:0] pc_dbg
);
    logic [AW-1:0]     pc_q;
    logic [OPW-1:0]    ir_q;
    logic              halt_q;
    logic [SW-1:0]     step;
    logic [STEPS-1:0]  step_oh;
    logic [NLINES-1:0] lines;
    ctrl_t             ctrl;
    logic [DW-1:0]     mdr;
    logic [DW-1:0]     acc;
    logic              flag_n;
    logic              flag_z;

    cpu_sequencer #(.STEPS(STEPS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (~halt_q),
        .step    (step),
        .step_oh (step_oh)
    );

    cpu_ctrl_decode u_dec (
        .opcode  (ir_q),
        .step_oh (step_oh),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .lines   (lines),
        .ctrl    (ctrl)
    );

    cpu_alu_acc u_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_ld  (ctrl.acc_ld),
        .alu_sel (ctrl.alu_sel),
        .operand (mdr),
        .acc     (acc),
        .flag_n  (flag_n),
        .flag_z  (flag_z)
    );

    cpu_memory #(.AW(AW), .DW(DW)) u_mem (
        .clk          (clk),
        .rst_n        (rst_n),
        .mar_ld       (ctrl.mar_ld),
        .mar_from_bus (ctrl.mar_from_bus),
        .pc           (pc_q),
        .mem_rd       (ctrl.mem_rd),
        .mem_wr       (ctrl.mem_wr),
        .wdata        (acc),
        .pre_we       (pre_we),
        .pre_addr     (pre_addr),
        .pre_data     (pre_data),
        .mdr          (mdr)
    );

    // Program counter: jump load or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (ctrl.pc_ld) begin
            pc_q <= mdr[AW-1:0];
        end else if (ctrl.pc_inc) begin
            pc_q <= pc_q + AW'(1);
        end
    end

    // Opcode register keeps only the decoded field of the fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= OP_NOP;
        end else if (ctrl.ir_ld) begin
            ir_q <= mdr[DW-1:DW-OPW];
        end
    end

    // Halt latch, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (ctrl.halt) begin
            halt_q <= 1'b1;
        end
    end

    assign halted  = halt_q;
    assign acc_dbg = acc;
    assign pc_dbg  = pc_q;
endmodule

// File: rtl/acc_cpu_chk.sv
// Checker bound to acc_cpu: step progression, register write windows,
// flag tracking, decoder one-hot and halt freeze.
module acc_cpu_chk #(
    parameter int SW = 3,
    parameter int NL = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halted,
    input logic [7:0]    pc,
    input logic [7:0]    acc,
    input logic [3:0]    ir,
    input logic [SW-1:0] step,
    input logic          flag_n,
    input logic          flag_z,
    input logic [NL-1:0] lines
);
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (step == SW'($past(step) + SW'(1)))); // R3

    AST_IR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step != SW'(2)) |=> $stable(ir)); // R4

    AST_PC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(step == SW'(1) || step == SW'(4) || step == SW'(5)) |=> $stable(pc)); // R13

    AST_ACC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(step == SW'(3) || step == SW'(7)) |=> $stable(acc)); // R6

    AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_n == acc[7]) && (flag_z == (acc == 8'h00))); // R9

    AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lines) == 1); // R5

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc))); // R12
endmodule

bind acc_cpu acc_cpu_chk #(.SW(cpu_pkg::SW), .NL(cpu_pkg::NLINES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .halted (halted),
    .pc     (pc_q),
    .acc    (acc),
    .ir     (ir_q),
    .step   (step),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .lines  (lines)
);

// File: tb/tb_acc_cpu.sv
// Self-checking bench: preloads short programs, runs them to halt and
// compares accumulator, program counter and halt cycle with computed values.
module tb_acc_cpu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = 8'h00;
    logic [7:0] pre_data = 8'h00;
    logic       halted;
    logic [7:0] acc_dbg;
    logic [7:0] pc_dbg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    acc_cpu dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .halted   (halted),
        .acc_dbg  (acc_dbg),
        .pc_dbg   (pc_dbg)
    );

    always #4 clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic start();
        @(negedge clk);
        pre_we = 1'b0;
        rst_n  = 1'b0;
        @(posedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_we   = 1'b1;
        pre_addr = a;
        pre_data = d;
        @(posedge clk);
    endtask

    // Release reset and run to halt; k is the index of the halt instruction.
    task automatic go(input string req, input int k, input int exp_pc, input int exp_acc);
        int j;
        @(negedge clk);
        pre_we = 1'b0;
        rst_n  = 1'b1;
        j = 0;
        while (j < 400) begin
            @(posedge clk);
            j++;
            @(negedge clk);
            if (halted) break;
        end
        chk({req, " R3 halt edge"}, j, 8 * k + 4);
        chk({req, " R12 pc"}, int'(pc_dbg), exp_pc);
        chk({req, " acc"}, int'(acc_dbg), exp_acc);
    endtask

    initial begin
        // R1: reset state.
        start();
        @(negedge clk);
        chk("R1 pc", int'(pc_dbg), 0);
        chk("R1 acc", int'(acc_dbg), 0);
        chk("R1 halted", int'(halted), 0);

        // R2 R6 R5: LDA then ALU op, low nibble of opcodes varied.
        for (int op = 3; op <= 5; op++) begin
            for (int a = 0; a < 256; a += 17) begin
                for (int b = 0; b < 256; b += 13) begin
                    int e;
                    if (op == 3) e = (a + b) & 8'hFF;
                    else if (op == 4) e = a | b;
                    else e = a & b;
                    start();
                    wr(8'h00, 8'h20 | 8'(a & 15));
                    wr(8'h01, 8'h40);
                    wr(8'h02, 8'((op << 4) | (b & 15)));
                    wr(8'h03, 8'h41);
                    wr(8'h04, 8'hF0);
                    wr(8'h40, 8'(a));
                    wr(8'h41, 8'(b));
                    go("R6 R2 alu", 2, 5, e);
                end
            end
        end

        // R7: invert every value.
        for (int a = 0; a < 256; a++) begin
            start();
            wr(8'h00, 8'h20);
            wr(8'h01, 8'h40);
            wr(8'h02, 8'h6A);
            wr(8'h03, 8'hF0);
            wr(8'h40, 8'(a));
            go("R7 not", 2, 4, (~a) & 8'hFF);
        end

        // R8: store, corrupt accumulator, reload.
        for (int a = 0; a < 256; a += 15) begin
            start();
            wr(8'h00, 8'h20);
            wr(8'h01, 8'h40);
            wr(8'h02, 8'h10);
            wr(8'h03, 8'h90);
            wr(8'h04, 8'h60);
            wr(8'h05, 8'h20);
            wr(8'h06, 8'h90);
            wr(8'h07, 8'hF0);
            wr(8'h40, 8'(a));
            wr(8'h90, 8'(a ^ 8'h5A));
            go("R8 sta", 4, 8, a);
        end

        // R5: no-op and unused opcodes are one byte and leave the accumulator.
        for (int u = 0; u < 16; u++) begin
            if (u == 0 || u == 7 || (u >= 11 && u <= 14)) begin
                start();
                wr(8'h00, 8'h20);
                wr(8'h01, 8'h40);
                wr(8'h02, 8'((u << 4) | 3));
                wr(8'h03, 8'hF0);
                wr(8'h40, 8'h3C);
                go("R5 nop", 2, 4, 8'h3C);
            end
        end

        // R11 R9: conditional jumps over every accumulator value.
        for (int x = 0; x < 256; x++) begin
            start();
            wr(8'h00, 8'h20);
            wr(8'h01, 8'h80);
            wr(8'h02, 8'hA0);
            wr(8'h03, 8'h10);
            wr(8'h04, 8'h90);
            wr(8'h05, 8'h20);
            wr(8'h06, 8'hF0);
            wr(8'h10, 8'hF0);
            wr(8'h20, 8'hF0);
            wr(8'h80, 8'(x));
            if (x == 0) go("R11 R9 jz", 2, 8'h11, x);
            else if (x >= 128) go("R11 R9 jn", 3, 8'h21, x);
            else go("R11 R9 none", 3, 7, x);
        end

        // R10 R12: unconditional jump, then halt persists.
        start();
        wr(8'h00, 8'h85);
        wr(8'h01, 8'h30);
        wr(8'h30, 8'hF7);
        go("R10 jmp", 1, 8'h31, 0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R12 still halted", int'(halted), 1);
        chk("R12 pc frozen", int'(pc_dbg), 8'h31);
        chk("R13 pc frozen", int'(pc_dbg), 8'h31);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule